// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst in a synchronous burst memory. When either of two active-low address strobes is seen on a rising clock edge, it captures an external word address and starts a new burst at beat zero. On each later edge where neither strobe is active, the advance input decides what happens. If advance is active, the burst moves to its next beat. If advance is inactive, the burst is suspended and the current address is presented again.

Only the two least significant address bits ever change within a burst, and they wrap inside the same aligned four-word block. The upper bits keep the value they were loaded with. A mode input chooses the order of the low bits. Mode 0 gives linear order: the starting value plus the beat number, modulo 4. Mode 1 gives interleaved order: the starting value XOR the beat number. A board that leaves this pin floating should tie it to 1 at instantiation, which selects interleaved order. The strobes are assumed to arrive already qualified by any chip-enable logic.

Internally, a decoder turns the three control inputs into one of three named commands: CMD_LOAD, CMD_STEP or CMD_HOLD, with CMD_LOAD taking priority. A register stage holds the loaded address and the beat count. An order map builds the low bits from the registered start value, the beat count and the mode.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst is high at a rising edge, the address register and the beat count are cleared, so addr_out and beat read 0 after that edge, even if a strobe is active at the same time.
- R2: If strobe_p_n or strobe_c_n is low at a rising edge, addr_out equals the addr_in sampled at that edge and beat reads 0 afterwards.
- R3: A strobe load overrides an advance in the same cycle: with a strobe low and adv_n low, the result is a load with beat 0.
- R4: With both strobes high and adv_n low at a rising edge, beat increments by one modulo 4, so 3 is followed by 0.
- R5: With both strobes high and adv_n high at a rising edge, beat and addr_out keep their previous values.
- R6: Within a burst, the bits of addr_out above bit 1 stay as loaded, including after the beat wraps. An advance never carries into them.
- R7: With mode = 0 (linear), addr_out[1:0] equals (loaded low bits + beat) modulo 4.
- R8: With mode = 1 (interleaved), addr_out[1:0] equals the loaded low bits XOR beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_p_n | input | 1 | First address strobe, active low, already qualified |
| strobe_c_n | input | 1 | Second address strobe, active low, already qualified |
| adv_n | input | 1 | Burst advance, active low |
| mode | input | 1 | Order select: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External word address captured on a strobe |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Position within the burst, 0 to 3 |

## Verification
The suspend check expects a stable address only when mode has not moved between the two edges, because mode is read live and does not take part in the hold. For the same reason, the stimulus changes mode only while a new burst is being loaded, never in the middle of a burst. The strobes and advance are driven as clean levels well away from the clock edge. The sweep covers both orders, all four starting low values, several upper-bit patterns, each strobe on its own, both strobes together, and suspend cycles placed inside the wrap.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int LO_W = 2;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic       strobe_p_n,
    input  logic       strobe_c_n,
    input  logic       adv_n,
    output burst_cmd_e cmd
);
    // A strobe outranks advance; advance outranks suspend.
    always_comb begin
        if (!strobe_p_n || !strobe_c_n) begin
            cmd = CMD_LOAD;
        end else if (!adv_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    always_comb begin
        assert_load_priority_R3: assert ((strobe_p_n && strobe_c_n) || cmd == CMD_LOAD);
    end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [LO_W-1:0]   beat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    base_q <= addr_in;
                    beat_q <= '0;
                end
                CMD_STEP: beat_q <= beat_q + 1'b1;
                CMD_HOLD: beat_q <= beat_q;
                default:  beat_q <= beat_q;
            endcase
        end
    end

    assert_step_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (beat_q == LO_W'($past(beat_q) + 1'b1)));

    assert_base_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> $stable(base_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  logic [LO_W-1:0] start_lo,
    input  logic [LO_W-1:0] beat,
    input  logic            mode,
    output logic [LO_W-1:0] lo
);
    logic [LO_W-1:0] lo_linear;
    logic [LO_W-1:0] lo_interleave;

    always_comb begin
        lo_linear     = start_lo + beat;
        lo_interleave = start_lo ^ beat;
        lo            = mode ? lo_interleave : lo_linear;
    end

    // Beat zero is the starting word in both orders.
    always_comb begin
        assert_first_beat_start_R2: assert (beat != '0 || lo == start_lo);
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_p_n,
    input  logic              strobe_c_n,
    input  logic              adv_n,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat
);
    burst_cmd_e        cmd;
    logic [ADDR_W-1:0] base_q;
    logic [LO_W-1:0]   beat_q;
    logic [LO_W-1:0]   lo;

    burst_cmd_decode i_decode (
        .strobe_p_n (strobe_p_n),
        .strobe_c_n (strobe_c_n),
        .adv_n      (adv_n),
        .cmd        (cmd)
    );

    burst_beat_counter #(.ADDR_W(ADDR_W)) i_counter (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr_in (addr_in),
        .base_q  (base_q),
        .beat_q  (beat_q)
    );

    burst_order_map i_order (
        .start_lo (base_q[LO_W-1:0]),
        .beat     (beat_q),
        .mode     (mode),
        .lo       (lo)
    );

    always_comb begin
        addr_out = {base_q[ADDR_W-1:LO_W], lo};
        beat     = beat_q;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && beat == 2'd0));

    assert_strobe_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (!strobe_p_n || !strobe_c_n) |=> (addr_out == $past(addr_in) && beat == 2'd0));

    assert_suspend_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe_p_n && strobe_c_n && adv_n) |=>
            ($stable(beat) && (!$stable(mode) || $stable(addr_out))));

    assert_upper_no_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (strobe_p_n && strobe_c_n) |=> $stable(addr_out[ADDR_W-1:LO_W]));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          strobe_p_n;
    logic          strobe_c_n;
    logic          adv_n;
    logic          mode;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int tests_run = 0;
    int tests_failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk(clk), .rst(rst), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
        .adv_n(adv_n), .mode(mode), .addr_in(addr_in),
        .addr_out(addr_out), .beat(beat)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int actual, input int expected);
        tests_run++;
        if (actual != expected) begin
            tests_failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    function automatic int exp_lo(input int m, input int s, input int n);
        if (m == 1) return (s ^ (n % 4)) & 3;
        return (s + n) % 4;
    endfunction

    initial begin
        int uppers[3];
        uppers[0] = 0; uppers[1] = 63; uppers[2] = 21;
        rst = 1'b1; strobe_p_n = 1'b0; strobe_c_n = 1'b1; adv_n = 1'b0;
        mode = 1'b1; addr_in = 8'hAB;
        tick(); tick();
        check("R1 reset addr", addr_out, 0);
        check("R1 reset beat", beat, 0);
        rst = 1'b0; strobe_p_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int ui = 0; ui < 3; ui++) begin
                    int u;
                    u = uppers[ui];
                    mode = m[0];
                    addr_in = AW'((u << 2) | s);
                    if (s[0]) strobe_c_n = 1'b0; else strobe_p_n = 1'b0;
                    adv_n = 1'b1;
                    tick();
                    check("R2 load addr", addr_out, (u << 2) | s);
                    check("R2 load beat", beat, 0);
                    strobe_p_n = 1'b1; strobe_c_n = 1'b1;
                    addr_in = ~addr_in;
                    for (int n = 1; n <= 6; n++) begin
                        if (n == 4) begin
                            adv_n = 1'b1;
                            tick();
                            check("R5 suspend beat", beat, 3);
                            check("R5 suspend addr", addr_out, (u << 2) | exp_lo(m, s, 3));
                        end
                        adv_n = 1'b0;
                        tick();
                        check("R4 beat", beat, n % 4);
                        check("R6 upper", addr_out >> 2, u);
                        if (m == 1) check("R8 interleaved lo", addr_out & 3, exp_lo(m, s, n));
                        else        check("R7 linear lo", addr_out & 3, exp_lo(m, s, n));
                    end
                end
            end
        end

        // Load against advance, both strobes together
        strobe_p_n = 1'b0; strobe_c_n = 1'b0; adv_n = 1'b0; addr_in = 8'h5E; mode = 1'b0;
        tick();
        check("R3 priority addr", addr_out, 8'h5E);
        check("R3 priority beat", beat, 0);
        strobe_p_n = 1'b1; strobe_c_n = 1'b0; addr_in = 8'hC1;
        tick();
        check("R3 second strobe addr", addr_out, 8'hC1);
        check("R3 second strobe beat", beat, 0);
        strobe_c_n = 1'b1;
        tick();
        tick();
        check("R7 linear from 01", addr_out, 8'hC3);
        rst = 1'b1;
        tick();
        check("R1 mid-burst reset addr", addr_out, 0);
        check("R1 mid-burst reset beat", beat, 0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule